// File: doc/BRIEF.md
# Indexed Event Counter Bank

This block is a bank of event counters for processor performance monitoring. Each counter watches one of several condition lines coming from the core. It adds one on every clock where that line is high, counting can be limited to kernel or user privilege, and a single run bit can hold every counter still at once. Software reaches the bank through a narrow register port of 32-bit words. An index register chooses one counter, and the configuration, count, threshold and snapshot registers then act on that counter only.

A counter is stopped by giving it condition number 0, which never fires. To read a running counter without tearing, software takes a snapshot that copies the chosen counter into a two-word holding register. Software then reads both halves at leisure. Each counter also has a threshold. When an increment brings the counter to that value, and the counter's interrupt enable is set, the counter raises its interrupt-active flag. The flags are ORed into one interrupt line. Clearing a flag also drops that counter's enable, so software re-arms it after servicing.

Top module: `ecb_bank`

## Requirements
- R1: After reset every counter, threshold, configuration, the run bit, the index, all interrupt enables and all active flags are zero, and `irq` is low.
- R2: Register offsets on `reg_addr` are: 0 control, 1 index, 2 config, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 threshold low, 8 threshold high, 9 interrupt enable (bit i = counter i), 10 interrupt active (bit i = counter i). Accesses at offsets 2, 3, 4, 7 and 8 touch only the counter named by the index register. Reads return data on `reg_rdata` one clock after the address is presented.
- R3: A counter adds one on each clock where the run bit is set, its chosen condition is high and its mode qualifier allows the current mode. Condition number k (1..NUM_COND) is `cond_in[k-1]`. Config bits 14:0 hold the condition number. Counters wrap at their width.
- R4: Condition number 0, and any number above NUM_COND, never counts.
- R5: Config bit 16 permits counting while `kernel_mode` is 1, and config bit 17 permits counting while `kernel_mode` is 0. With neither bit set, both modes count. With both set, both modes count.
- R6: Control bit 0 is the run bit. While it is 0, no counter changes except by a software preset.
- R7: Writing control with bit 1 set copies the selected counter, as it stood before that write, into the snapshot registers. The snapshot stays unchanged until the next snapshot command, while the counter runs on.
- R8: Writing count low or count high presets that half of the selected counter and wins over an increment in the same clock. The counter width is 32 + 16*WIDE_SEL. Count high returns the bits above 31, and a carry out of bit 31 reaches them.
- R9: When an increment makes a counter equal to its threshold and that counter's enable bit is 1, its active bit is set. With the enable bit at 0, no active bit is set.
- R10: Writing 1s to the active register clears those active bits and the same counters' enable bits. Writing all ones clears every flag.
- R11: `irq` is high exactly when any active bit is set, and it drops once all are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cond_in | input | NUM_COND | Event condition lines, condition k on bit k-1 |
| kernel_mode | input | 1 | 1 while the core runs in kernel mode, 0 in user mode |
| irq | output | 1 | Registered OR of all interrupt-active bits |

## Verification
The hardest case to reach from the ports is a software preset and an increment landing on the same counter in the same clock. Only one register access fits in each clock, and the counter normally moves while software is busy elsewhere. The stimulus holds a condition line high across the write and the read that follows it, so the outcome of that clash can be seen. The carry into the upper half of a 48-bit counter is reached by presetting the counter just below the 32-bit boundary. Long runs of random condition and mode patterns are checked against a model of every counter's qualifier.

// File: rtl/ecb_pkg.sv
`timescale 1ns/1ps
package ecb_pkg;
  typedef enum logic [3:0] {
    A_CTRL    = 4'd0,
    A_SEL     = 4'd1,
    A_CFG     = 4'd2,
    A_CNT_LO  = 4'd3,
    A_CNT_HI  = 4'd4,
    A_SNAP_LO = 4'd5,
    A_SNAP_HI = 4'd6,
    A_THR_LO  = 4'd7,
    A_THR_HI  = 4'd8,
    A_IEN     = 4'd9,
    A_IACT    = 4'd10
  } reg_addr_e;

  // Per-counter selection: condition number plus privilege qualifiers
  typedef struct packed {
    logic        user_only;
    logic        kern_only;
    logic [14:0] cond;
  } cnt_cfg_t;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SNAP_BIT = 1;
  localparam int CFG_KERN_BIT  = 16;
  localparam int CFG_USER_BIT  = 17;
endpackage

// File: rtl/ecb_qualify.sv
`timescale 1ns/1ps
module ecb_qualify #(
  parameter int NUM_COND = 8
) (
  input  logic [NUM_COND-1:0] cond_in,
  input  ecb_pkg::cnt_cfg_t   cfg,
  input  logic                kernel_mode,
  input  logic                run,
  output logic                inc
);
  logic picked;
  logic mode_ok;

  // Condition 0 and out-of-range numbers match no line, so they never fire
  always_comb begin
    picked = 1'b0;
    for (int j = 0; j < NUM_COND; j++) begin
      if (cfg.cond == 15'(j + 1)) picked = cond_in[j];
    end
  end

  assign mode_ok = (!cfg.kern_only && !cfg.user_only) ||
                   (cfg.kern_only && kernel_mode) ||
                   (cfg.user_only && !kernel_mode);

  assign inc = run && picked && mode_ok;
endmodule

// File: rtl/ecb_counter.sv
`timescale 1ns/1ps
module ecb_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          cnt_ld_lo,
  input  logic          cnt_ld_hi,
  input  logic          thr_ld_lo,
  input  logic          thr_ld_hi,
  input  logic [31:0]   wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] thr,
  output logic          hit
);
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] cnt_wr;
  logic [CW-1:0] thr_wr;
  logic          ld;

  assign ld      = cnt_ld_lo || cnt_ld_hi;
  assign cnt_inc = cnt + CW'(1);

  generate
    if (CW > 32) begin : g_wide
      assign cnt_wr = cnt_ld_lo ? {cnt[CW-1:32], wdata} : {wdata[CW-33:0], cnt[31:0]};
      assign thr_wr = thr_ld_lo ? {thr[CW-1:32], wdata} : {wdata[CW-33:0], thr[31:0]};
    end else begin : g_narrow
      // No upper half: a high-word write leaves the value as it is
      assign cnt_wr = cnt_ld_lo ? wdata[CW-1:0] : cnt;
      assign thr_wr = thr_ld_lo ? wdata[CW-1:0] : thr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      thr <= '0;
    end else begin
      if (ld)       cnt <= cnt_wr;   // software preset beats the event
      else if (inc) cnt <= cnt_inc;
      if (thr_ld_lo || thr_ld_hi) thr <= thr_wr;
    end
  end

  assign hit = inc && !ld && (cnt_inc == thr);
endmodule

// File: rtl/ecb_irq.sv
`timescale 1ns/1ps
module ecb_irq #(
  parameter int NUM_CTRS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CTRS-1:0] hit,
  input  logic                ien_we,
  input  logic                iact_we,
  input  logic [NUM_CTRS-1:0] wdata,
  output logic [NUM_CTRS-1:0] ien,
  output logic [NUM_CTRS-1:0] act,
  output logic                irq
);
  logic [NUM_CTRS-1:0] clr;
  logic [NUM_CTRS-1:0] ien_nxt;
  logic [NUM_CTRS-1:0] act_nxt;

  assign clr     = iact_we ? wdata : '0;
  assign ien_nxt = (ien_we ? wdata : ien) & ~clr;
  assign act_nxt = (act | (hit & ien)) & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
      act <= '0;
      irq <= 1'b0;
    end else begin
      ien <= ien_nxt;
      act <= act_nxt;
      irq <= |act_nxt;
    end
  end
endmodule

// File: rtl/ecb_bank.sv
`timescale 1ns/1ps
module ecb_bank #(
  parameter int NUM_CTRS = 4,
  parameter int WIDE_SEL = 0,
  parameter int NUM_COND = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_COND-1:0] cond_in,
  input  logic                kernel_mode,
  output logic                irq
);
  import ecb_pkg::*;

  localparam int CW    = 32 + 16 * WIDE_SEL;
  localparam int IDX_W = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1;

  logic              run_q;
  logic [IDX_W-1:0]  sel_q;
  cnt_cfg_t          cfg_q [NUM_CTRS];
  logic [CW-1:0]     snap_q;

  logic [CW-1:0]     cnt_arr [NUM_CTRS];
  logic [CW-1:0]     thr_arr [NUM_CTRS];
  logic [NUM_CTRS-1:0] inc_v, hit_v;
  logic [NUM_CTRS-1:0] ien_q, act_q;

  logic wr_ctrl, wr_sel, wr_cfg, wr_cnt_lo, wr_cnt_hi, wr_thr_lo, wr_thr_hi, wr_ien, wr_iact;

  assign wr_ctrl   = reg_we && (reg_addr == A_CTRL);
  assign wr_sel    = reg_we && (reg_addr == A_SEL);
  assign wr_cfg    = reg_we && (reg_addr == A_CFG);
  assign wr_cnt_lo = reg_we && (reg_addr == A_CNT_LO);
  assign wr_cnt_hi = reg_we && (reg_addr == A_CNT_HI);
  assign wr_thr_lo = reg_we && (reg_addr == A_THR_LO);
  assign wr_thr_hi = reg_we && (reg_addr == A_THR_HI);
  assign wr_ien    = reg_we && (reg_addr == A_IEN);
  assign wr_iact   = reg_we && (reg_addr == A_IACT);

  // Selected-counter views for reads and snapshot
  logic [CW-1:0] cnt_sel, thr_sel;
  cnt_cfg_t      cfg_sel;
  always_comb begin
    cnt_sel = '0;
    thr_sel = '0;
    cfg_sel = '0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (sel_q == IDX_W'(i)) begin
        cnt_sel = cnt_arr[i];
        thr_sel = thr_arr[i];
        cfg_sel = cfg_q[i];
      end
    end
  end

  logic [31:0] cnt_sel_hi, thr_sel_hi, snap_hi;
  generate
    if (CW > 32) begin : g_hi
      assign cnt_sel_hi = 32'(cnt_sel[CW-1:32]);
      assign thr_sel_hi = 32'(thr_sel[CW-1:32]);
      assign snap_hi    = 32'(snap_q[CW-1:32]);
    end else begin : g_no_hi
      assign cnt_sel_hi = '0;
      assign thr_sel_hi = '0;
      assign snap_hi    = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      sel_q  <= '0;
      snap_q <= '0;
      for (int i = 0; i < NUM_CTRS; i++) cfg_q[i] <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= reg_wdata[CTRL_RUN_BIT];
        if (reg_wdata[CTRL_SNAP_BIT]) snap_q <= cnt_sel;
      end
      if (wr_sel) sel_q <= reg_wdata[IDX_W-1:0];
      for (int i = 0; i < NUM_CTRS; i++) begin
        if (wr_cfg && sel_q == IDX_W'(i)) begin
          cfg_q[i].cond      <= reg_wdata[14:0];
          cfg_q[i].kern_only <= reg_wdata[CFG_KERN_BIT];
          cfg_q[i].user_only <= reg_wdata[CFG_USER_BIT];
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
      logic is_sel;
      assign is_sel = (sel_q == IDX_W'(g));

      ecb_qualify #(.NUM_COND(NUM_COND)) u_qual (
        .cond_in     (cond_in),
        .cfg         (cfg_q[g]),
        .kernel_mode (kernel_mode),
        .run         (run_q),
        .inc         (inc_v[g])
      );

      ecb_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .inc       (inc_v[g]),
        .cnt_ld_lo (wr_cnt_lo && is_sel),
        .cnt_ld_hi (wr_cnt_hi && is_sel),
        .thr_ld_lo (wr_thr_lo && is_sel),
        .thr_ld_hi (wr_thr_hi && is_sel),
        .wdata     (reg_wdata),
        .cnt       (cnt_arr[g]),
        .thr       (thr_arr[g]),
        .hit       (hit_v[g])
      );
    end
  endgenerate

  ecb_irq #(.NUM_CTRS(NUM_CTRS)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit_v),
    .ien_we  (wr_ien),
    .iact_we (wr_iact),
    .wdata   (reg_wdata[NUM_CTRS-1:0]),
    .ien     (ien_q),
    .act     (act_q),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_CTRL:    reg_rdata <= {31'b0, run_q};
        A_SEL:     reg_rdata <= 32'(sel_q);
        A_CFG:     reg_rdata <= {14'b0, cfg_sel.user_only, cfg_sel.kern_only, 1'b0, cfg_sel.cond};
        A_CNT_LO:  reg_rdata <= cnt_sel[31:0];
        A_CNT_HI:  reg_rdata <= cnt_sel_hi;
        A_SNAP_LO: reg_rdata <= snap_q[31:0];
        A_SNAP_HI: reg_rdata <= snap_hi;
        A_THR_LO:  reg_rdata <= thr_sel[31:0];
        A_THR_HI:  reg_rdata <= thr_sel_hi;
        A_IEN:     reg_rdata <= 32'(ien_q);
        A_IACT:    reg_rdata <= 32'(act_q);
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ecb_bank_chk.sv
`timescale 1ns/1ps
module ecb_bank_chk #(
  parameter int NUM_CTRS = 4,
  parameter int CW       = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_we,
  input logic [3:0]          reg_addr,
  input logic [31:0]         reg_wdata,
  input logic                irq,
  input logic                run_q,
  input logic [CW-1:0]       cnt_sel,
  input logic [CW-1:0]       snap_q,
  input logic [NUM_CTRS-1:0] ien,
  input logic [NUM_CTRS-1:0] act
);
  import ecb_pkg::*;

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq && act == '0 && ien == '0 && !run_q));

  // R6
  p_run_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !(reg_we && (reg_addr == A_CNT_LO || reg_addr == A_CNT_HI || reg_addr == A_SEL)))
    |=> $stable(cnt_sel));

  // R7
  p_snap_copy_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CTRL && reg_wdata[CTRL_SNAP_BIT]) |=> (snap_q == $past(cnt_sel)));

  // R8
  p_preset_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CNT_LO) |=> (cnt_sel[31:0] == $past(reg_wdata)));

  // R9
  p_act_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    ((act & ~$past(act)) != '0) |-> ((act & ~$past(act) & ~$past(ien)) == '0));

  // R10
  p_clr_drops_en_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_IACT) |=>
      (((ien | act) & $past(reg_wdata[NUM_CTRS-1:0])) == '0));

  // R11
  p_irq_up_r11: assert property (@(posedge clk) disable iff (rst)
    (act != '0) |-> irq);
  p_irq_down_r11: assert property (@(posedge clk) disable iff (rst)
    (act == '0) |-> !irq);
endmodule

bind ecb_bank ecb_bank_chk #(.NUM_CTRS(NUM_CTRS), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .run_q     (run_q),
  .cnt_sel   (cnt_sel),
  .snap_q    (snap_q),
  .ien       (ien_q),
  .act       (act_q)
);

// File: tb/ecb_bank_test.sv
`timescale 1ns/1ps
module ecb_bank_test;
  localparam int N  = 4;
  localparam int M  = 8;
  localparam int CW = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [M-1:0]  cond_in = '0;
  logic          kernel_mode = 1'b0;
  logic          irq;

  always #4 clk = ~clk;

  ecb_bank #(.NUM_CTRS(N), .WIDE_SEL(1), .NUM_COND(M)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cond_in(cond_in),
    .kernel_mode(kernel_mode), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [CW-1:0] m_cnt [N];
  int            m_cond [N];
  bit            m_k [N];
  bit            m_u [N];
  bit            m_run = 0;
  logic [CW-1:0] snap_exp;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rdchk(string req, int a, logic [31:0] exp);
    @(negedge clk); reg_we = 1'b0; reg_addr = 4'(a);
    @(negedge clk); chk(req, reg_rdata, exp);
  endtask

  function automatic bit counts(int i, logic [M-1:0] v, bit km);
    bit p, mok;
    p   = (m_cond[i] >= 1 && m_cond[i] <= M) ? v[m_cond[i]-1] : 1'b0;
    mok = (!m_k[i] && !m_u[i]) || (m_k[i] && km) || (m_u[i] && !km);
    return m_run && p && mok;
  endfunction

  task automatic set_cfg(int i, int c, bit k, bit u);
    wr(1, i);
    wr(2, {14'b0, u, k, 1'b0, 15'(c)});
    m_cond[i] = c; m_k[i] = k; m_u[i] = u;
  endtask

  task automatic preset(int i, logic [CW-1:0] v);
    wr(1, i);
    wr(3, v[31:0]);
    wr(4, 32'(v[CW-1:32]));
    m_cnt[i] = v;
  endtask

  task automatic rand_phase(int n);
    for (int k = 0; k < n; k++) begin
      logic [31:0] r;
      @(negedge clk);
      r = $urandom;
      cond_in = r[M-1:0];
      kernel_mode = r[8];
      for (int i = 0; i < N; i++)
        if (counts(i, r[M-1:0], r[8])) m_cnt[i] = m_cnt[i] + 1'b1;
    end
    @(negedge clk); cond_in = '0;
  endtask

  task automatic drive(logic [M-1:0] v, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cond_in = v;
    end
    @(negedge clk); cond_in = '0;
  endtask

  task automatic cmp_all(string req);
    for (int i = 0; i < N; i++) begin
      wr(1, i);
      rdchk(req, 3, m_cnt[i][31:0]);
      rdchk(req, 4, 32'(m_cnt[i][CW-1:32]));
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = '0; m_cond[i] = 0; m_k[i] = 0; m_u[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rdchk("R1", 0, 32'h0);
    rdchk("R1", 3, 32'h0);
    rdchk("R1", 10, 32'h0);
    chk("R1", 32'(irq), 32'h0);

    // R3 / R5 random counting with mixed qualifiers
    wr(0, 32'h1); m_run = 1;
    set_cfg(0, 1, 0, 0);
    set_cfg(1, 3, 1, 0);
    set_cfg(2, 8, 0, 1);
    set_cfg(3, 5, 1, 1);
    for (int i = 0; i < N; i++) preset(i, 48'(i * 1000));
    rand_phase(300);
    cmp_all("R3 R5");

    // R4 never conditions
    set_cfg(0, 0, 0, 0);
    set_cfg(1, 9, 0, 0);
    rand_phase(100);
    cmp_all("R4");

    // R6 run bit off
    wr(0, 32'h0); m_run = 0;
    rand_phase(100);
    cmp_all("R6");
    wr(0, 32'h1); m_run = 1;

    // R2 index isolation
    preset(2, 48'hABCD);
    wr(1, 1);
    rdchk("R2", 3, m_cnt[1][31:0]);
    wr(1, 2);
    rdchk("R2", 3, 32'hABCD);
    rdchk("R2", 2, 32'h0002_0008);

    // R8 carry into the upper half
    set_cfg(0, 1, 0, 0);
    preset(0, {16'h1234, 32'hFFFF_FFFF});
    drive(8'h01, 1);
    rdchk("R8", 3, 32'h0);
    rdchk("R8", 4, 32'h0000_1235);

    // R8 preset wins over a same-cycle increment
    @(negedge clk); cond_in = 8'h01; reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 32'h50;
    @(negedge clk); reg_we = 1'b0;
    @(negedge clk); chk("R8", reg_rdata, 32'h50); cond_in = '0;
    m_cnt[0] = {16'h1235, 32'h51};

    // R7 snapshot holds while the counter runs on
    wr(0, 32'h3);
    snap_exp = m_cnt[0];
    rand_phase(50);
    rdchk("R7", 5, snap_exp[31:0]);
    rdchk("R7", 6, 32'(snap_exp[CW-1:32]));
    rdchk("R7", 3, m_cnt[0][31:0]);

    // R9 threshold without enable
    set_cfg(3, 5, 0, 0);
    preset(3, '0);
    wr(7, 32'd6); wr(8, 32'd0);
    drive(8'h10, 6);
    rdchk("R9", 10, 32'h0);
    chk("R11", 32'(irq), 32'h0);

    // R9 threshold with enable
    preset(3, '0);
    wr(9, 32'h8);
    drive(8'h10, 6);
    rdchk("R9", 10, 32'h8);
    chk("R11", 32'(irq), 32'h1);
    rdchk("R10", 9, 32'h8);

    // R10 clearing a flag drops its enable
    wr(10, 32'h8);
    rdchk("R10", 10, 32'h0);
    rdchk("R10", 9, 32'h0);
    chk("R11", 32'(irq), 32'h0);

    // R10 all-ones clear of two flags
    set_cfg(2, 2, 0, 0);
    preset(2, '0);
    wr(7, 32'd3); wr(8, 32'd0);
    preset(3, '0);
    wr(9, 32'hC);
    drive(8'h12, 6);
    rdchk("R9", 10, 32'hC);
    chk("R11", 32'(irq), 32'h1);
    wr(10, 32'hFFFF_FFFF);
    rdchk("R10", 10, 32'h0);
    rdchk("R10", 9, 32'h0);
    chk("R11", 32'(irq), 32'h0);

    finished = 1;
    summary();
    $finish;
  end
endmodule